// File: doc/BRIEF.md
# Show Cycle Bus Exporter

This block copies each internal bus transfer onto the external bus so that off-chip equipment can trace internal activity. Each accepted transfer gives exactly one external cycle, one clock later. In that cycle the block raises the external data strobe, puts the transfer size on the external size lines and, where the external bus should carry data, drives the data bus with its output enable. A 2-bit enable field selects whether internal transfers are shown. It also selects whether internal traffic stalls while an external master holds the bus.

The internal transfer port is a valid/ready stream. A transfer is taken on a clock edge where `cyc_valid` and `cyc_ready` are both high. `cyc_ready` drops whenever the block requests a halt, which is the back-pressure path. A source that sees `cyc_ready` low must hold its transfer until `cyc_ready` returns. Addresses at or above the parameter `EXT_BASE` count as external. All other addresses are internal. The data bus is big-endian: an even byte address uses bits 15:8 and an odd byte address uses bits 7:0. The grant, the enable field and the halt request are plain control pins.

Top module: `shc_exporter`

## Requirements
- R1: While `rst_n` is low and after reset with no transfer, `ext_ds`, `ext_data_oe`, `halt_req` are 0, `ext_size` is 0 and `ext_data` is 0.
- R2: With `show_mode` 01, 10 or 11, an accepted internal-address transfer gives, in the following cycle, `ext_ds`=1, `ext_data_oe`=1 and `ext_size` equal to `cyc_size`. For a word (size 10) or a read, `ext_data` equals `cyc_data`.
- R3: With `show_mode` 00, an accepted internal-address transfer gives `ext_ds`=0, `ext_data_oe`=0, `ext_size`=0 and `ext_data`=0 in the following cycle.
- R4: An accepted external-address byte write (size 01) drives the written byte on both halves of `ext_data`, with `ext_ds`=1 and `ext_data_oe`=1, in every `show_mode`. The written byte is bits 15:8 of `cyc_data` for an even address and bits 7:0 for an odd address.
- R5: For an internal byte write shown on the external bus, the lane selected by address bit 0 equals the same lane of `cyc_data`. The other lane is undefined.
- R6: An accepted external-address read gives `ext_ds`=1, `ext_size`=`cyc_size` and `ext_data_oe`=0 in the following cycle, in every `show_mode`.
- R7: With `show_mode` 11, `halt_req` rises in the same cycle as `ext_grant`, and `cyc_ready` is low whenever `halt_req` is high.
- R8: With `show_mode` 11, `halt_req` remains high in the cycle where `ext_grant` falls and is low in the cycle after.
- R9: With `show_mode` 00, 01 or 10, `ext_grant` never raises `halt_req`, and transfers keep being accepted.
- R10: A cycle without an accepted transfer (valid low, or held off by ready) gives `ext_ds`=0 and `ext_data_oe`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| show_mode | input | 2 | Enable field: 00 off, 01/10 on, 11 on with halt during grant |
| ext_grant | input | 1 | External master holds the bus |
| cyc_valid | input | 1 | Internal transfer present |
| cyc_ready | output | 1 | Transfer can be taken (low while halting) |
| cyc_addr | input | AW (24) | Transfer address |
| cyc_data | input | DW (16) | Transfer data |
| cyc_size | input | 2 | Size code: 01 byte, 10 word |
| cyc_write | input | 1 | 1 = write, 0 = read |
| ext_ds | output | 1 | External data strobe |
| ext_size | output | 2 | External size lines |
| ext_data | output | DW (16) | External data bus |
| ext_data_oe | output | 1 | Data bus output enable |
| halt_req | output | 1 | Halt request to the internal bus |

## Verification
The halt path and the transfer path can fall in the same cycle. A grant can arrive under mode 11 in the same cycle that a transfer is offered. The bench sweeps every mode, grant state, read/write, size, address region and byte lane, with `cyc_valid` both high and low. A reference model of the halt timing predicts whether the transfer is refused. A refused transfer must leave the strobe low in the next cycle. An accepted one must show the expected strobe, size and data.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    SHOW_OFF  = 2'b00,
    SHOW_ON   = 2'b01,
    SHOW_ALT  = 2'b10,
    SHOW_HALT = 2'b11
  } show_mode_e;

  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/shc_mode_dec.sv
module shc_mode_dec
  import shc_pkg::*;
(
  input  logic [1:0] mode,
  output logic       show_on,
  output logic       halt_mode
);
  show_mode_e m;
  always_comb begin
    m         = show_mode_e'(mode);
    show_on   = (m != SHOW_OFF);
    halt_mode = (m == SHOW_HALT);
  end
endmodule

// File: rtl/shc_halt_ctl.sv
module shc_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic halt_mode,
  output logic halt
);
  logic now_q;
  logic now_c;
  assign now_c = grant & halt_mode;
  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= 1'b0;
    else        now_q <= now_c;
  end
  // raise at once, drop one cycle after the grant goes
  assign halt = now_c | now_q;
endmodule

// File: rtl/shc_lane_mux.sv
module shc_lane_mux
  import shc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] din,
  input  logic          odd,
  input  logic [1:0]    size,
  input  logic          wr,
  input  logic          ext,
  output logic [DW-1:0] dout
);
  localparam int HW = DW / 2;
  logic [HW-1:0] sel;
  always_comb begin
    sel  = odd ? din[HW-1:0] : din[DW-1:HW];
    dout = din;
    if (ext && wr && size == SZ_BYTE) dout = {sel, sel};
  end
endmodule

// File: rtl/shc_exporter.sv
module shc_exporter
  import shc_pkg::*;
#(
  parameter int              AW       = 24,
  parameter int              DW       = 16,
  parameter logic [AW-1:0]   EXT_BASE = 24'h800000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    show_mode,
  input  logic          ext_grant,
  input  logic          cyc_valid,
  output logic          cyc_ready,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_data,
  input  logic [1:0]    cyc_size,
  input  logic          cyc_write,
  output logic          ext_ds,
  output logic [1:0]    ext_size,
  output logic [DW-1:0] ext_data,
  output logic          ext_data_oe,
  output logic          halt_req
);
  logic          show_on, halt_mode, is_ext, take, drive, oe_c;
  logic [DW-1:0] muxed;

  shc_mode_dec u_dec (.mode(show_mode), .show_on(show_on), .halt_mode(halt_mode));

  shc_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .grant(ext_grant),
    .halt_mode(halt_mode), .halt(halt_req)
  );

  shc_lane_mux #(.DW(DW)) u_mux (
    .din(cyc_data), .odd(cyc_addr[0]), .size(cyc_size),
    .wr(cyc_write), .ext(is_ext), .dout(muxed)
  );

  assign cyc_ready = ~halt_req;
  assign is_ext    = (cyc_addr >= EXT_BASE);
  assign take      = cyc_valid & cyc_ready;
  assign drive     = take & (show_on | is_ext);
  assign oe_c      = take & (is_ext ? cyc_write : show_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_ds      <= 1'b0;
      ext_size    <= 2'b00;
      ext_data    <= '0;
      ext_data_oe <= 1'b0;
    end else begin
      ext_ds      <= drive;
      ext_size    <= drive ? cyc_size : 2'b00;
      ext_data    <= oe_c ? muxed : '0;
      ext_data_oe <= oe_c;
    end
  end
endmodule

// File: rtl/shc_exporter_chk.sv
module shc_exporter_chk #(
  parameter int            AW       = 24,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] EXT_BASE = 24'h800000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    show_mode,
  input logic          ext_grant,
  input logic          cyc_valid,
  input logic          cyc_ready,
  input logic [AW-1:0] cyc_addr,
  input logic [1:0]    cyc_size,
  input logic          cyc_write,
  input logic          ext_ds,
  input logic [DW-1:0] ext_data,
  input logic          ext_data_oe,
  input logic          halt_req
);
  localparam int HW = DW / 2;

  // R7
  halt_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_grant && show_mode == 2'b11) |-> halt_req);
  // R7
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !cyc_ready);
  // R8
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_grant && !$past(ext_grant)) |-> !halt_req);
  // R10
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_valid && cyc_ready) |-> (!ext_ds && !ext_data_oe));
  // R3
  off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_valid && cyc_ready && show_mode == 2'b00 && !cyc_write) |-> !ext_data_oe);
  // R6
  ext_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_valid && cyc_ready && !cyc_write && cyc_addr >= EXT_BASE) |-> (ext_ds && !ext_data_oe));
  // R4
  ext_byte_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_valid && cyc_ready && cyc_write && cyc_size == 2'b01 && cyc_addr >= EXT_BASE)
      |-> (ext_data[DW-1:HW] == ext_data[HW-1:0]));
endmodule

bind shc_exporter shc_exporter_chk #(.AW(AW), .DW(DW), .EXT_BASE(EXT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .show_mode(show_mode), .ext_grant(ext_grant),
  .cyc_valid(cyc_valid), .cyc_ready(cyc_ready), .cyc_addr(cyc_addr),
  .cyc_size(cyc_size), .cyc_write(cyc_write), .ext_ds(ext_ds),
  .ext_data(ext_data), .ext_data_oe(ext_data_oe), .halt_req(halt_req)
);

// File: tb/shc_exporter_test.sv
`timescale 1ns/100ps
module shc_exporter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  show_mode = 2'b00;
  logic        ext_grant = 1'b0;
  logic        cyc_valid = 1'b0;
  logic        cyc_ready;
  logic [23:0] cyc_addr = '0;
  logic [15:0] cyc_data = '0;
  logic [1:0]  cyc_size = 2'b10;
  logic        cyc_write = 1'b0;
  logic        ext_ds;
  logic [1:0]  ext_size;
  logic [15:0] ext_data;
  logic        ext_data_oe;
  logic        halt_req;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // expectations for the cycle after the current one
  bit         p_acc = 0, p_ext = 0, p_wr = 0, p_show = 0, p_odd = 0;
  logic [1:0] p_sz = 0;
  logic [15:0] p_dat = 0;
  bit hq = 0;

  always #2 clk = ~clk;

  shc_exporter uut (
    .clk(clk), .rst_n(rst_n), .show_mode(show_mode), .ext_grant(ext_grant),
    .cyc_valid(cyc_valid), .cyc_ready(cyc_ready), .cyc_addr(cyc_addr),
    .cyc_data(cyc_data), .cyc_size(cyc_size), .cyc_write(cyc_write),
    .ext_ds(ext_ds), .ext_size(ext_size), .ext_data(ext_data),
    .ext_data_oe(ext_data_oe), .halt_req(halt_req)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_outputs();
    bit drive, oe;
    logic [7:0] b;
    drive = p_acc && (p_show || p_ext);
    oe    = p_acc && (p_ext ? p_wr : p_show);
    if (!p_acc) begin
      chk("R10 ds", ext_ds, 0);
      chk("R10 oe", ext_data_oe, 0);
    end else if (p_ext) begin
      chk(p_wr ? "R4 ds" : "R6 ds", ext_ds, 1);
      chk(p_wr ? "R4 oe" : "R6 oe", ext_data_oe, oe);
      chk("R6 size", ext_size, p_sz);
      if (p_wr && p_sz == 2'b01) begin
        b = p_odd ? p_dat[7:0] : p_dat[15:8];
        chk("R4 data", ext_data, {b, b});
      end else if (p_wr) chk("R2 ext word data", ext_data, p_dat);
    end else if (p_show) begin
      chk("R2 ds", ext_ds, 1);
      chk("R2 oe", ext_data_oe, 1);
      chk("R2 size", ext_size, p_sz);
      if (p_wr && p_sz == 2'b01) begin
        if (p_odd) chk("R5 lane", ext_data[7:0], p_dat[7:0]);
        else       chk("R5 lane", ext_data[15:8], p_dat[15:8]);
      end else chk("R2 data", ext_data, p_dat);
    end else begin
      chk("R3 ds", ext_ds, 0);
      chk("R3 oe", ext_data_oe, 0);
      chk("R3 size", ext_size, 0);
      chk("R3 data", ext_data, 0);
    end
    if (!drive) chk("R10 size", ext_size, 0);
  endtask

  task automatic step(bit v, logic [1:0] m, bit g, bit ext, bit wr,
                      logic [1:0] sz, bit odd, logic [15:0] d);
    bit eh;
    @(negedge clk);
    check_outputs();
    show_mode = m; ext_grant = g; cyc_valid = v; cyc_write = wr;
    cyc_size = sz; cyc_data = d;
    cyc_addr = (ext ? 24'h812340 : 24'h001230) | {23'd0, odd};
    #1;
    eh = (g && m == 2'b11) || hq;
    if (m == 2'b11) chk((!g && hq) ? "R8 hold" : "R7 halt", halt_req, eh);
    else            chk((!g && hq) ? "R8 release" : "R9 no halt", halt_req, eh);
    chk("R7 ready", cyc_ready, !eh);
    p_acc = v && !eh; p_ext = ext; p_wr = wr; p_show = (m != 2'b00);
    p_odd = odd; p_sz = sz; p_dat = d;
    @(posedge clk);
    hq = g && (m == 2'b11);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ds", ext_ds, 0);
    chk("R1 oe", ext_data_oe, 0);
    chk("R1 halt", halt_req, 0);
    chk("R1 data", ext_data, 0);
    chk("R1 size", ext_size, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int g = 0; g < 2; g++)
        for (int e = 0; e < 2; e++)
          for (int w = 0; w < 2; w++)
            for (int s = 1; s < 3; s++)
              for (int a = 0; a < 2; a++)
                for (int v = 0; v < 2; v++)
                  step(v[0], m[1:0], g[0], e[0], w[0], s[1:0], a[0],
                       16'(16'h1357 * (m * 64 + g * 32 + e * 16 + w * 8 + s * 4 + a * 2 + v + 1)));
    // grant drop sequence under halting mode
    step(1, 2'b11, 1, 0, 1, 2'b10, 0, 16'hA5C3);
    step(1, 2'b11, 0, 0, 1, 2'b10, 0, 16'h5A3C);
    step(1, 2'b11, 0, 0, 1, 2'b10, 0, 16'hBEEF);
    step(0, 2'b00, 0, 0, 0, 2'b10, 0, 16'h0000);
    step(0, 2'b00, 0, 0, 0, 2'b10, 0, 16'h0000);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule